// File: doc/BRIEF.md
# Configuration Access Address Translator

This block turns a configuration-space request from a host requester into the settings and bus address used for one access through an outbound address-translation window. Each request carries a 16-bit target identifier (bus, device, function) and a 12-bit register offset. The block first decides whether the addressed function can exist in the supported topology. It then picks the configuration transaction type and routes the access.

Accesses to the root bus go straight to the local register block and are not translated. Accesses to any other bus use one fixed translation window. The window's target word is rewritten for every access, and the access itself lands in the top megabyte of that window.

An illegal target is flagged rather than routed. The requester then completes a read with all-ones data, or discards a write. All results are registered and appear exactly one clock after the request strobe.

Top module: `cfgx_xlate_top`

## Requirements
- R1: A request is illegal when its bus is 0 and its device is above 1, or when its bus is 1 and its device is above 0. Every other request is legal, and `out_ok` reports legality.
- R2: An illegal read (`req_write`=0) raises `out_fill`, which tells the requester to complete with 0xFFFFFFFF. `out_drop` stays low, and `out_type`, `out_target` and `out_addr` are all 0.
- R3: An illegal write raises `out_drop`, which means the write is discarded. `out_fill` stays low, and type, target and address are all 0. A legal request raises neither flag.
- R4: A legal request to bus 0 or bus 1 gets type code 4, which selects a type-0 configuration access.
- R5: A legal request to bus 2 or above gets type code 5, which selects a type-1 configuration access.
- R6: A legal request to bus 0 sets `out_local`, gives target 0, and gives address 0x01FFC000 plus the aligned offset.
- R7: A legal request to any other bus clears `out_local` and gives a target word with the identifier in bits 31:16. That places the bus in bits 31:24, the device in bits 23:19 and the function in bits 18:16, with bits 15:0 zero.
- R8: A legal request to any other bus gives address 0x01F00000 plus the aligned offset. This is the base of the 16 MB window (0x01000000) plus 15 MB.
- R9: The two low offset bits are ignored. The aligned offset is the offset with bits 1:0 cleared.
- R10: `out_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. The other outputs update on that edge and hold their values otherwise.
- R11: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_id | input | 16 | Target identifier: bus [15:8], device [7:3], function [2:0] |
| req_off | input | 12 | Configuration register byte offset |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_ok | output | 1 | Target is legal |
| out_local | output | 1 | Access goes to the local registers, untranslated |
| out_fill | output | 1 | Illegal read: complete with all ones |
| out_drop | output | 1 | Illegal write: discard |
| out_type | output | 4 | Translation type code: 4 for type-0, 5 for type-1, 0 when illegal |
| out_target | output | 32 | Translation target word |
| out_addr | output | 32 | Bus address to access |

## Verification
The assertions assume that `req_id` and `req_off` are stable only during the cycle in which `req_valid` is high. They also assume that no rule ties successive requests together, so any request may follow any other, including back to back.

The stimulus drives each request for one cycle away from the clock edge and sweeps every device and function on a spread of buses, including 0, 1, 2 and 255. It alternates reads and writes and varies the offset, including its two low bits. One burst of back-to-back strobes exercises the one-cycle latency without idle gaps.

// File: rtl/cfgx_pkg.sv
// Shared widths and transaction type codes for the configuration translator.
// Assumes a 32-bit bus address and a 16-bit bus/device/function identifier.
package cfgx_pkg;
    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int ID_W  = BUS_W + DEV_W + FN_W;
    localparam int AW    = 32;

    typedef enum logic [3:0] {
        XK_NONE = 4'd0,
        XK_CFG0 = 4'd4,
        XK_CFG1 = 4'd5
    } xkind_e;
endpackage

// File: rtl/cfgx_legal_chk.sv
// Decides whether a target can exist in the supported topology and whether
// it sits on the root bus. Assumes bus 0 and bus 1 have limited device counts.
module cfgx_legal_chk #(
    parameter int BUS_W        = 8,
    parameter int DEV_W        = 5,
    parameter int ROOT_DEV_MAX = 1,
    parameter int NEXT_DEV_MAX = 0
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    output logic             legal,
    output logic             on_root
);
    localparam logic [DEV_W-1:0] ROOT_LIM = DEV_W'(ROOT_DEV_MAX);
    localparam logic [DEV_W-1:0] NEXT_LIM = DEV_W'(NEXT_DEV_MAX);

    // Topology limit: device range is capped on bus 0 and bus 1.
    always_comb begin
        on_root = (bus == '0);
        legal   = 1'b1;
        if (on_root && dev > ROOT_LIM)
            legal = 1'b0;
        if (bus == BUS_W'(1) && dev > NEXT_LIM)
            legal = 1'b0;
    end
endmodule

// File: rtl/cfgx_kind_sel.sv
// Selects the configuration transaction type code for a request.
// Assumes type-0 is used for the root bus and the bus right below it.
module cfgx_kind_sel #(
    parameter int BUS_W = 8
) (
    input  logic              [BUS_W-1:0] bus,
    input  logic                          legal,
    output cfgx_pkg::xkind_e              kind
);
    // Type choice: illegal gives none, low buses type-0, the rest type-1.
    always_comb begin
        if (!legal)
            kind = cfgx_pkg::XK_NONE;
        else if (bus < BUS_W'(2))
            kind = cfgx_pkg::XK_CFG0;
        else
            kind = cfgx_pkg::XK_CFG1;
    end
endmodule

// File: rtl/cfgx_addr_gen.sv
// Builds the translation target word and the final bus address.
// Assumes the remote slot is the top 2**SLOT_LOG2 bytes of a 2**WIN_LOG2 window.
module cfgx_addr_gen #(
    parameter int              ID_W       = 16,
    parameter int              OFF_W      = 12,
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   LOCAL_BASE = 32'h01FF_C000,
    parameter logic [AW-1:0]   WIN_BASE   = 32'h0100_0000,
    parameter int              WIN_LOG2   = 24,
    parameter int              SLOT_LOG2  = 20
) (
    input  logic [ID_W-1:0]  id,
    input  logic [OFF_W-1:0] off,
    input  logic             legal,
    input  logic             on_root,
    output logic [AW-1:0]    target,
    output logic [AW-1:0]    addr
);
    localparam logic [AW-1:0] REMOTE_BASE =
        WIN_BASE + AW'(64'(1) << WIN_LOG2) - AW'(64'(1) << SLOT_LOG2);

    logic [AW-1:0] off_word;

    // Word alignment: drop the two byte-select bits of the offset.
    always_comb off_word = {{(AW-OFF_W){1'b0}}, off[OFF_W-1:2], 2'b00};

    // Routing: local base untranslated, remote slot with packed identifier.
    always_comb begin
        target = '0;
        addr   = '0;
        if (legal && on_root) begin
            addr = LOCAL_BASE + off_word;
        end else if (legal) begin
            target = {id, {(AW-ID_W){1'b0}}};
            addr   = REMOTE_BASE + off_word;
        end
    end
endmodule

// File: rtl/cfgx_xlate_top.sv
// Configuration access translator: checks the target, picks the type code,
// builds target word and bus address, and registers all of it one cycle
// after the request strobe. Assumes one request per strobe cycle.
module cfgx_xlate_top #(
    parameter int            OFF_W        = 12,
    parameter int            ROOT_DEV_MAX = 1,
    parameter int            NEXT_DEV_MAX = 0,
    parameter logic [31:0]   LOCAL_BASE   = 32'h01FF_C000,
    parameter logic [31:0]   WIN_BASE     = 32'h0100_0000,
    parameter int            WIN_LOG2     = 24,
    parameter int            SLOT_LOG2    = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_id,
    input  logic [11:0] req_off,
    output logic        out_valid,
    output logic        out_ok,
    output logic        out_local,
    output logic        out_fill,
    output logic        out_drop,
    output logic [3:0]  out_type,
    output logic [31:0] out_target,
    output logic [31:0] out_addr
);
    import cfgx_pkg::*;

    localparam logic [AW-1:0] REMOTE_BASE =
        WIN_BASE + AW'(64'(1) << WIN_LOG2) - AW'(64'(1) << SLOT_LOG2);

    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic             legal;
    logic             on_root;
    xkind_e           kind;
    logic [AW-1:0]    target_c;
    logic [AW-1:0]    addr_c;

    // Field split of the identifier.
    always_comb begin
        bus = req_id[ID_W-1 -: BUS_W];
        dev = req_id[FN_W +: DEV_W];
    end

    cfgx_legal_chk #(
        .BUS_W(BUS_W), .DEV_W(DEV_W),
        .ROOT_DEV_MAX(ROOT_DEV_MAX), .NEXT_DEV_MAX(NEXT_DEV_MAX)
    ) u_legal (
        .bus(bus), .dev(dev), .legal(legal), .on_root(on_root)
    );

    cfgx_kind_sel #(.BUS_W(BUS_W)) u_kind (
        .bus(bus), .legal(legal), .kind(kind)
    );

    cfgx_addr_gen #(
        .ID_W(ID_W), .OFF_W(OFF_W), .AW(AW),
        .LOCAL_BASE(LOCAL_BASE), .WIN_BASE(WIN_BASE),
        .WIN_LOG2(WIN_LOG2), .SLOT_LOG2(SLOT_LOG2)
    ) u_addr (
        .id(req_id), .off(req_off), .legal(legal), .on_root(on_root),
        .target(target_c), .addr(addr_c)
    );

    // Result register: strobe every cycle, payload only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_ok     <= 1'b0;
            out_local  <= 1'b0;
            out_fill   <= 1'b0;
            out_drop   <= 1'b0;
            out_type   <= 4'd0;
            out_target <= '0;
            out_addr   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_ok     <= legal;
                out_local  <= legal && on_root;
                out_fill   <= !legal && !req_write;
                out_drop   <= !legal && req_write;
                out_type   <= kind;
                out_target <= target_c;
                out_addr   <= addr_c;
            end
        end
    end

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_type)));
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_ok, out_fill, out_drop}));
    p_write_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !out_fill);
    p_local_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_local) |-> (out_type == 4'd4 && out_target == '0));
    p_far_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == 4'd5) |-> (out_target[31:24] >= 8'd2));
    p_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ok && !out_local) |->
            (out_addr >= REMOTE_BASE && out_addr < REMOTE_BASE + AW'(64'(1) << OFF_W)));
    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[1:0] == 2'b00));
endmodule

// File: tb/test_cfgx_xlate_top.sv
module test_cfgx_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_id = '0;
    logic [11:0] req_off = '0;
    logic        out_valid, out_ok, out_local, out_fill, out_drop;
    logic [3:0]  out_type;
    logic [31:0] out_target, out_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cfgx_xlate_top i_cfgx_xlate_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_id(req_id), .req_off(req_off), .out_valid(out_valid),
        .out_ok(out_ok), .out_local(out_local), .out_fill(out_fill),
        .out_drop(out_drop), .out_type(out_type), .out_target(out_target),
        .out_addr(out_addr)
    );

    task automatic chk(input bit pass, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!pass) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result of one request, computed from the requirements.
    task automatic check_result(input logic [15:0] id, input logic [11:0] off,
                                input bit wr);
        logic [7:0] b;
        logic [4:0] d;
        bit ok, loc;
        logic [3:0] ty;
        logic [31:0] tg, ad, ow;
        b  = id[15:8];
        d  = id[7:3];
        ok = !((b == 0 && d > 1) || (b == 1 && d > 0));
        loc = ok && b == 0;
        ow = {20'd0, off[11:2], 2'b00};
        ty = !ok ? 4'd0 : (b < 2 ? 4'd4 : 4'd5);
        tg = (ok && !loc) ? {id, 16'h0} : 32'h0;
        ad = !ok ? 32'h0 : (loc ? 32'h01FFC000 + ow : 32'h01F00000 + ow);
        chk(out_valid === 1'b1, "R10 valid", {31'd0, out_valid}, 1);
        chk(out_ok === ok, "R1 ok", {31'd0, out_ok}, {31'd0, ok});
        chk(out_fill === (!ok && !wr), "R2 fill", {31'd0, out_fill}, {31'd0, !ok && !wr});
        chk(out_drop === (!ok && wr), "R3 drop", {31'd0, out_drop}, {31'd0, !ok && wr});
        chk(out_type === ty, (b < 2) ? "R4 type" : "R5 type", {28'd0, out_type}, {28'd0, ty});
        chk(out_local === loc, "R6 local", {31'd0, out_local}, {31'd0, loc});
        chk(out_target === tg, "R7 target", out_target, tg);
        chk(out_addr === ad, loc ? "R6 addr" : "R8 addr", out_addr, ad);
    endtask

    task automatic one_req(input logic [15:0] id, input logic [11:0] off, input bit wr);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_off = off; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check_result(id, off, wr);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] buses [6] = '{8'd0, 8'd1, 8'd2, 8'd7, 8'd128, 8'd255};
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid === 0 && out_ok === 0 && out_local === 0 && out_fill === 0 &&
            out_drop === 0, "R11 flags", {27'd0, out_valid, out_ok, out_local, out_fill, out_drop}, 0);
        chk(out_type === 0 && out_target === 0 && out_addr === 0, "R11 data",
            out_addr | out_target | {28'd0, out_type}, 0);
        rst_n = 1'b1;

        // R1..R8 sweep: every device and function on a set of buses
        for (int bi = 0; bi < 6; bi++)
            for (int df = 0; df < 256; df++)
                one_req({buses[bi], 8'(df)}, 12'((df * 37 + bi * 101) & 12'hFFF), df[0]);

        // R9: low offset bits ignored
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a0;
            one_req(16'h0308, 12'h3C0, 1'b0);
            a0 = out_addr;
            one_req(16'h0308, 12'(12'h3C0 + k), 1'b0);
            chk(out_addr === a0, "R9 low bits", out_addr, a0);
        end

        // R10: strobe drops after request, payload holds
        @(negedge clk);
        chk(out_valid === 0, "R10 idle", {31'd0, out_valid}, 0);
        chk(out_addr === 32'h01F003C0, "R10 hold", out_addr, 32'h01F003C0);

        // R10: back-to-back requests
        @(negedge clk);
        req_valid = 1; req_id = 16'h0000; req_off = 12'h010; req_write = 0;
        @(negedge clk);
        check_result(16'h0000, 12'h010, 0);
        req_id = 16'h0210; req_off = 12'hFFF; req_write = 1;
        @(negedge clk);
        check_result(16'h0210, 12'hFFF, 1);
        req_id = 16'h0010; req_off = 12'h004; req_write = 1;
        @(negedge clk);
        req_valid = 0;
        check_result(16'h0010, 12'h004, 1);

        // R11: reset again clears everything
        rst_n = 0;
        @(negedge clk);
        chk(out_valid === 0 && out_addr === 0 && out_drop === 0, "R11 rereset",
            out_addr, 0);
        rst_n = 1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule